// File: doc/BRIEF.md
# Synchronous Serial Frame Master

This block sends and receives asynchronous-style character frames, and also drives a serial clock for a slave device that has no clock of its own. Each frame is one start bit (low), eight data bits sent least significant bit first, and one stop bit (high). The TX line idles high. Bit timing comes from a programmable divisor that gives sixteen internal ticks per bit.

The serial clock pulses only while data bits are on the line. It stays at its idle level while the line is idle and during the start and stop bits. One input sets that idle level. Another input sets which half of the bit carries the active clock phase. A third input sets whether the eighth data bit gets a pulse.

The receive path needs no oversampling. When receive is enabled, RX is captured once per data bit, at the mid-bit tick. That tick coincides with the capturing clock edge. The received byte appears with a one-cycle strobe once the stop bit ends. A transmit byte is taken through a valid/ready handshake, and only while the engine is idle.

Top module: `sync_usart_master`

## Requirements
- R1: After reset, TX is high, `busy` and `rx_valid` are low, `tx_ready` is high, and SCLK equals `cfg_cpol`.
- R2: After a byte is accepted, TX carries start (0), then data bits 0 to 7, then stop (1). Each bit lasts 16*(`cfg_div`+1) cycles, and the start bit begins at the accepting edge.
- R3: SCLK equals `cfg_cpol` while the engine is idle and during the start and stop bits of every frame.
- R4: With `cfg_lastclk`=1 all eight data bits are clocked, giving 16 SCLK transitions per frame. With `cfg_lastclk`=0 SCLK stays at `cfg_cpol` during data bit 7, giving 14 transitions.
- R5: The SCLK idle level follows `cfg_cpol`: 0 gives idle low, 1 gives idle high.
- R6: In a clocked data bit, tick index t (0..15) gives SCLK = `cfg_cpol` XOR (t[3] XOR `cfg_cpha`). With `cfg_cpha`=0 the first edge is at mid-bit. With `cfg_cpha`=1 the first edge is at the bit start and the second edge at mid-bit.
- R7: With `rx_en`=1, RX is sampled once per data bit at the mid-bit tick. Bit 7 is also sampled there when it is not clocked. The samples assemble least significant bit first.
- R8: `rx_valid` pulses high for exactly one cycle, in the cycle in which `busy` first reads low after the stop bit. `rx_data` then holds the received byte.
- R9: `busy` is high and `tx_ready` is low from the accepting edge until the stop bit ends.
- R10: `tx_valid` asserted while busy has no effect: the frame in flight is unchanged and no further frame starts.
- R11: With `rx_en`=0, no `rx_valid` pulse occurs.
- R12: The frame lasts exactly 160*(`cfg_div`+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0: clock active in the second half of the bit; 1: active in the first half |
| cfg_lastclk | input | 1 | Clock the final data bit |
| cfg_div | input | DIV_W | Tick period minus one, in clock cycles |
| rx_en | input | 1 | Receive enable |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte accepted when high with tx_valid |
| rx | input | 1 | Serial data in |
| tx | output | 1 | Serial data out |
| sclk | output | 1 | Serial clock out |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| busy | output | 1 | Frame in progress |

## Verification
The accepting edge is cycle zero. With D = `cfg_div`, bit k of TX starts k*16*(D+1) cycles later. Tick t of that bit starts t*(D+1) cycles after the bit start, and SCLK changes in that same cycle. The capture edge for data bit k is (16k+8)*(D+1) edges after the accepting edge. `busy` falls and `rx_valid` rises together, 160*(D+1) edges after that edge. The bench counts cycles from the accepting edge, samples every output on the falling clock edge of each cycle, and compares against values computed from that count. It drives RX on falling edges, so RX is steady across each capture edge.

// File: rtl/sync_usart_master.sv
module sync_usart_master #(
  parameter int DIV_W     = 8,
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_cpol,
  input  logic                 cfg_cpha,
  input  logic                 cfg_lastclk,
  input  logic [DIV_W-1:0]     cfg_div,
  input  logic                 rx_en,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic                 rx,
  output logic                 tx,
  output logic                 sclk,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 busy
);
  localparam int TW = $clog2(OSR);
  localparam int BW = $clog2(DATA_BITS);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t                  st;
  logic [DIV_W-1:0]     pre;
  logic [TW-1:0]        tcnt;
  logic [BW-1:0]        bidx;
  logic [DATA_BITS-1:0] tsh, rsh;

  wire tick     = (st != S_IDLE) && (pre == cfg_div);
  wire bit_end  = tick && (tcnt == TW'(OSR - 1));
  wire mid      = tick && (tcnt == TW'(OSR/2 - 1));
  wire last_bit = (bidx == BW'(DATA_BITS - 1));
  wire clk_slot = (st == S_DATA) && (!last_bit || cfg_lastclk);

  assign sclk     = cfg_cpol ^ (clk_slot && (tcnt[TW-1] ^ cfg_cpha));
  assign tx       = (st == S_START) ? 1'b0 : (st == S_DATA) ? tsh[0] : 1'b1;
  assign busy     = (st != S_IDLE);
  assign tx_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pre      <= '0;
      tcnt     <= '0;
      bidx     <= '0;
      tsh      <= '0;
      rsh      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (st == S_IDLE) begin
        pre  <= '0;
        tcnt <= '0;
        bidx <= '0;
        if (tx_valid) begin
          tsh <= tx_data;
          st  <= S_START;
        end
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) tcnt <= bit_end ? '0 : tcnt + 1'b1;
        if (mid && st == S_DATA && rx_en) rsh <= {rx, rsh[DATA_BITS-1:1]};
        if (bit_end) begin
          case (st)
            S_START: st <= S_DATA;
            S_DATA: begin
              tsh <= tsh >> 1;
              if (last_bit) st <= S_STOP;
              else          bidx <= bidx + 1'b1;
            end
            S_STOP: begin
              st       <= S_IDLE;
              rx_valid <= rx_en;
              rx_data  <= rsh;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sync_usart_master_chk.sv
module sync_usart_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_cpol,
  input logic       cfg_lastclk,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx,
  input logic       sclk,
  input logic       busy,
  input logic       rx_valid,
  input logic [1:0] st,
  input logic       on_last
);
  a_r3_idle_sclk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cfg_cpol);
  a_r1_idle_tx: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);
  a_r3_edge_bits_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 || st == 2'd3) |-> sclk == cfg_cpol);
  a_r4_last_unclocked: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && on_last && !cfg_lastclk) |-> sclk == cfg_cpol);
  a_r9_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (busy && !tx && !tx_ready));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r8_pulse_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $fell(busy));
endmodule

bind sync_usart_master sync_usart_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_lastclk(cfg_lastclk),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx(tx), .sclk(sclk),
  .busy(busy), .rx_valid(rx_valid), .st(st), .on_last(last_bit)
);

// File: tb/sync_usart_master_tb.sv
module sync_usart_master_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_lastclk = 1, rx_en = 1;
  logic [7:0] cfg_div = 0, tx_data = 0, rx_data;
  logic tx_valid = 0, tx_ready, rx = 1, tx, sclk, rx_valid, busy;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_usart_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lastclk(cfg_lastclk), .cfg_div(cfg_div), .rx_en(rx_en),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx(rx),
    .tx(tx), .sclk(sclk), .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_tx(int k, logic [7:0] d);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    return 1'b1;
  endfunction

  function automatic bit exp_sclk(int k, int t, bit pol, bit pha, bit last);
    bit clocked = (k >= 1 && k <= 8) && (k != 8 || last);
    return pol ^ (clocked && ((t >= 8) ^ pha));
  endfunction

  task automatic frame(input logic [7:0] d, input logic [7:0] rb, input bit pol,
                       input bit pha, input bit last, input int dv, input bit ren,
                       input bit inject);
    int per = 16 * (dv + 1);
    int total = 10 * per;
    int e_tx = 0, e_nd = 0, e_d = 0, e_last = 0, e_bsy = 0, e_v = 0, edges = 0;
    bit prev;
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_lastclk = last; cfg_div = 8'(dv); rx_en = ren;
    #1;
    chk(sclk == pol, "R5 idle level", sclk, pol);
    prev = sclk;
    tx_data = d; tx_valid = 1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 0;
    for (int n = 0; n < total; n++) begin
      int k = n / per;
      int t = (n % per) / (dv + 1);
      bit es = exp_sclk(k, t, pol, pha, last);
      rx = (k >= 1 && k <= 8) ? rb[k-1] : 1'b1;
      if (inject && n == 40) begin tx_valid = 1; tx_data = ~d; end
      if (inject && n == 80) tx_valid = 0;
      if (tx !== exp_tx(k, d)) e_tx++;
      if (sclk !== prev) edges++;
      prev = sclk;
      if (sclk !== es) begin
        if (k == 8 && !last) e_last++;
        else if (k >= 1 && k <= 8) e_d++;
        else e_nd++;
      end
      if (busy !== 1'b1 || tx_ready !== 1'b0) e_bsy++;
      if (rx_valid !== 1'b0) e_v++;
      @(negedge clk);
    end
    if (sclk !== prev) edges++;
    chk(e_tx == 0, inject ? "R2/R10 tx frame" : "R2 tx frame", e_tx, 0);
    chk(e_nd == 0, "R3 quiet in start/stop", e_nd, 0);
    chk(e_d == 0, "R6 phase in data bits", e_d, 0);
    chk(e_last == 0 && edges == (last ? 16 : 14), "R4 last-bit clock edges", edges, last ? 16 : 14);
    chk(e_bsy == 0, "R9 busy/ready in frame", e_bsy, 0);
    chk(busy == 0 && tx_ready == 1, "R12 frame length", busy, 0);
    chk(rx_valid == ren && e_v == 0, ren ? "R8 valid at end" : "R11 no valid when disabled", rx_valid, ren);
    if (ren) chk(rx_data == rb, "R7 received byte", rx_data, rb);
    @(negedge clk);
    chk(rx_valid == 0, "R8 one-cycle strobe", rx_valid, 0);
    if (inject) chk(busy == 0, "R10 no queued frame", busy, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(tx == 1 && busy == 0 && tx_ready == 1 && rx_valid == 0 && sclk == cfg_cpol,
        "R1 reset state", {tx, busy, tx_ready, rx_valid}, 4'b1010);
    rst_n = 1;
    frame(8'hA5, 8'h3C, 0, 0, 1, 0, 1, 0);
    frame(8'h5A, 8'hC3, 0, 1, 1, 1, 1, 0);
    frame(8'h01, 8'h80, 1, 0, 1, 2, 1, 0);
    frame(8'h80, 8'h01, 1, 1, 1, 0, 1, 1);
    frame(8'hFF, 8'hFF, 0, 0, 0, 1, 1, 0);
    frame(8'h00, 8'h81, 1, 1, 0, 3, 1, 0);
    frame(8'h96, 8'h69, 0, 1, 0, 0, 0, 1);
    for (int i = 0; i < 8; i++)
      frame(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule